// File: doc/BRIEF.md
# Strip-Mining Lane Issuer

This block sits between a vector instruction front end and a SIMD back end that has a fixed number of lanes. It accepts one command at a time: an element count, a maximum vector length, the byte address of element zero, and an optional per-element predicate. It then cuts the work into passes. Each pass covers the smaller of the remaining element count and the maximum vector length. Each pass is issued as lane-wide chunks. With every chunk the block sends the address of the chunk's first element, that element's index, and a lane enable mask.

When fewer elements remain in a pass than there are lanes, only the low lanes are enabled, so software never writes cleanup code for leftover elements. If the command is predicated, the length-derived mask is also ANDed with the predicate bits for the elements the chunk covers. Chunks leave on a valid/ready handshake. A one-cycle done pulse marks the end of the command.

Top module: `strip_lane_issuer`

## Requirements
- R1: The length of each pass is min(remaining count, maximum vector length), and no chunk spans two passes. A maximum vector length of 0 is treated as 1.
- R2: Across all chunks of a command, exactly n elements are covered, with chunk indices rising from 0 without gaps. After the last chunk no further chunk appears.
- R3: chunk_addr equals cmd_base + 4 * chunk_index, for 32-bit elements. It therefore advances by four times the vector length per pass.
- R4: A chunk covers min(LANES, elements left in the current pass) elements. Bit l of chunk_mask (lane l, element chunk_index+l) may be 1 only for l below that count. Unpredicated, exactly those bits are 1.
- R5: When cmd_pred_en is 1, bit l of chunk_mask is additionally ANDed with bit (chunk_index+l) of cmd_pred. Predicate bits at or beyond MAX_ELEMS read as 0.
- R6: A maximum vector length of 1 yields one single-lane chunk per element, with mask 1 when unpredicated.
- R7: A command with n = 0 produces no chunk, and done is 1 in the cycle after the start.
- R8: While chunk_valid is 1 and chunk_ready is 0, chunk_valid, chunk_addr, chunk_index and chunk_mask hold their values.
- R9: cmd_valid is ignored while a command is in progress. The chunk sequence of the running command is unchanged.
- R10: done is a single-cycle pulse in the cycle after the handshake of the last chunk. It is never 1 together with chunk_valid.
- R11: After reset, chunk_valid and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a command (taken only when idle) |
| cmd_n | input | CNT_W | Element count, at most MAX_ELEMS |
| cmd_mvl | input | CNT_W | Maximum vector length per pass (0 acts as 1) |
| cmd_base | input | ADDR_W | Byte address of element 0 |
| cmd_pred_en | input | 1 | 1 = apply predicate |
| cmd_pred | input | MAX_ELEMS | Predicate, bit i belongs to element i |
| chunk_valid | output | 1 | Chunk available |
| chunk_ready | input | 1 | Back end accepts chunk |
| chunk_addr | output | ADDR_W | Byte address of the chunk's first element |
| chunk_index | output | CNT_W | Element index of lane 0 |
| chunk_mask | output | LANES | Lane enables, bit l = lane l |
| done | output | 1 | One-cycle pulse at command end |

## Verification
The bench sweeps every element count from 0 to MAX_ELEMS against maximum vector lengths 0 through 6, on a four-lane configuration. This hits passes shorter than, equal to, and longer than the lane count. A design that clamps only the final chunk instead of every pass tail would enable lanes past a pass boundary. One that mishandles a zero count would issue a phantom chunk or never raise done. Predicate patterns are checked at unaligned chunk offsets; an error in slice selection shows up as a mask taken from the wrong elements. Backpressure, and a start pulse during a stall, expose outputs that drift or a command that gets reloaded mid-stream.

// File: rtl/strip_lane_issuer.sv
module strip_lane_issuer #(
  parameter int LANES      = 8,
  parameter int MAX_ELEMS  = 64,
  parameter int ADDR_W     = 32,
  parameter int ELEM_SHIFT = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cmd_valid,
  input  logic [$clog2(MAX_ELEMS+1)-1:0]       cmd_n,
  input  logic [$clog2(MAX_ELEMS+1)-1:0]       cmd_mvl,
  input  logic [ADDR_W-1:0]                    cmd_base,
  input  logic                                 cmd_pred_en,
  input  logic [MAX_ELEMS-1:0]                 cmd_pred,
  output logic                                 chunk_valid,
  input  logic                                 chunk_ready,
  output logic [ADDR_W-1:0]                    chunk_addr,
  output logic [$clog2(MAX_ELEMS+1)-1:0]       chunk_index,
  output logic [LANES-1:0]                     chunk_mask,
  output logic                                 done
);
  localparam int CNT_W = $clog2(MAX_ELEMS+1);

  logic              busy;
  logic [CNT_W-1:0]  rem, pass_left, idx, mvl_q, cnt;
  logic [ADDR_W-1:0] base_q;
  logic              pen_q;
  logic [MAX_ELEMS-1:0] pred_q;
  logic [LANES-1:0]  tail;

  function automatic logic [CNT_W-1:0] min2(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  wire [CNT_W-1:0] mvl_eff = (cmd_mvl == '0) ? CNT_W'(1) : cmd_mvl;
  wire             fire    = busy && chunk_ready;
  wire [CNT_W-1:0] rem_nx  = rem - cnt;
  wire [CNT_W-1:0] pl_nx   = pass_left - cnt;

  assign cnt = min2(pass_left, CNT_W'(LANES));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign tail[l]       = CNT_W'(l) < cnt;
    assign chunk_mask[l] = tail[l] && (!pen_q || pred_q[l]);
  end

  assign chunk_valid = busy;
  assign chunk_index = idx;
  assign chunk_addr  = base_q + (ADDR_W'(idx) << ELEM_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      rem       <= '0;
      pass_left <= '0;
      idx       <= '0;
      mvl_q     <= '0;
      base_q    <= '0;
      pen_q     <= 1'b0;
      pred_q    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          idx       <= '0;
          rem       <= cmd_n;
          mvl_q     <= mvl_eff;
          pass_left <= min2(cmd_n, mvl_eff);
          base_q    <= cmd_base;
          pen_q     <= cmd_pred_en;
          pred_q    <= cmd_pred;
          busy      <= (cmd_n != '0);
          done      <= (cmd_n == '0);
        end
      end else if (fire) begin
        idx    <= idx + cnt;
        rem    <= rem_nx;
        pred_q <= pred_q >> cnt;
        if (pl_nx != '0) begin
          pass_left <= pl_nx;
        end else if (rem_nx != '0) begin
          pass_left <= min2(rem_nx, mvl_q);
        end else begin
          pass_left <= '0;
          busy      <= 1'b0;
          done      <= 1'b1;
        end
      end
    end
  end

  assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> (pass_left != '0) && (pass_left <= mvl_q) && (pass_left <= rem));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && chunk_ready) |=> !chunk_valid ||
      ((chunk_addr - $past(chunk_addr)) == (ADDR_W'(chunk_index - $past(chunk_index)) << ELEM_SHIFT)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && !chunk_ready) |=> chunk_valid && $stable(chunk_addr)
      && $stable(chunk_index) && $stable(chunk_mask));

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && !chunk_ready && cmd_valid) |=> $stable(rem) && $stable(pass_left) && $stable(base_q));

  assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!chunk_valid && cmd_valid && cmd_n == '0) |=> done && !chunk_valid);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !chunk_valid ##1 !done);

endmodule

// File: tb/strip_lane_issuer_test.sv
module strip_lane_issuer_test;
  localparam int LANES = 4;
  localparam int ME    = 16;
  localparam int CW    = $clog2(ME+1);

  logic clk = 0;
  logic rst_n = 0;
  logic cmd_valid = 0;
  logic [CW-1:0] cmd_n = 0, cmd_mvl = 0;
  logic [31:0] cmd_base = 0;
  logic cmd_pred_en = 0;
  logic [ME-1:0] cmd_pred = 0;
  logic chunk_valid, chunk_ready = 0, done;
  logic [31:0] chunk_addr;
  logic [CW-1:0] chunk_index;
  logic [LANES-1:0] chunk_mask;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  strip_lane_issuer #(.LANES(LANES), .MAX_ELEMS(ME), .ADDR_W(32), .ELEM_SHIFT(2)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_n(cmd_n), .cmd_mvl(cmd_mvl),
    .cmd_base(cmd_base), .cmd_pred_en(cmd_pred_en), .cmd_pred(cmd_pred),
    .chunk_valid(chunk_valid), .chunk_ready(chunk_ready), .chunk_addr(chunk_addr),
    .chunk_index(chunk_index), .chunk_mask(chunk_mask), .done(done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int n, input int mvl, input bit pen, input logic [ME-1:0] pred,
                     input bit stall, input bit inject);
    int rem, pl, idx, mv, vl, c, guard, nch;
    bit hold_pend, injected;
    logic [31:0] h_addr; logic [CW-1:0] h_idx; logic [LANES-1:0] h_mask;
    logic [LANES-1:0] em;
    logic [31:0] base;
    base = 32'h1000 + 32'(n * 64 + mvl * 4);
    @(negedge clk);
    cmd_valid = 1; cmd_n = CW'(n); cmd_mvl = CW'(mvl); cmd_base = base;
    cmd_pred_en = pen; cmd_pred = pred; chunk_ready = 0;
    rem = n; idx = 0; mv = (mvl == 0) ? 1 : mvl; guard = 0; nch = 0;
    hold_pend = 0; injected = 0;
    vl = (rem < mv) ? rem : mv; pl = vl;
    while (rem > 0) begin
      @(negedge clk);
      cmd_valid = 0;
      if (inject && nch >= 1 && !injected) begin
        cmd_valid = 1; cmd_n = 2; cmd_mvl = 1; cmd_base = 32'hdead0; injected = 1;
      end
      chunk_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      #1;
      guard++;
      if (guard > 500) begin
        chk(0, "watchdog-run", 0, 1);
        return;
      end
      if (hold_pend) begin
        chk(chunk_valid && chunk_addr == h_addr && chunk_index == h_idx && chunk_mask == h_mask,
            "R8", {chunk_addr, chunk_index}, {h_addr, h_idx});
        hold_pend = 0;
      end
      if (chunk_valid && !chunk_ready) begin
        hold_pend = 1; h_addr = chunk_addr; h_idx = chunk_index; h_mask = chunk_mask;
      end
      if (chunk_valid && chunk_ready) begin
        c = (pl < LANES) ? pl : LANES;
        for (int l = 0; l < LANES; l++)
          em[l] = (l < c) && (!pen || ((idx + l) < ME && pred[idx + l]));
        chk(int'(chunk_index) == idx, "R2", chunk_index, idx);
        chk(chunk_addr == base + 32'(idx * 4), "R3", chunk_addr, base + 32'(idx * 4));
        chk(chunk_mask == em, pen ? "R5" : (mv == 1 ? "R6" : "R4"), chunk_mask, em);
        chk(!done, "R10", done, 0);
        idx += c; pl -= c; rem -= c; nch++;
        if (pl == 0 && rem > 0) begin
          vl = (rem < mv) ? rem : mv; pl = vl;  // R1 next pass length
        end
      end
    end
    @(negedge clk); cmd_valid = 0; #1;
    chk(done && !chunk_valid, n == 0 ? "R7" : "R10", {done, chunk_valid}, 2'b10);
    @(negedge clk); #1;
    chk(!done && !chunk_valid, "R2", {done, chunk_valid}, 2'b00);
  endtask

  initial begin
    #(5 * 150000);
    chk(0, "watchdog", 0, 1);
    if (!finished) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!chunk_valid && !done, "R11", {chunk_valid, done}, 0);
    rst_n = 1;
    for (int n = 0; n <= ME; n++)
      for (int m = 0; m <= 6; m++)
        run(n, m, 0, '0, (n + m) % 2 == 1, 0);
    run(ME, 16, 1, 16'hA5C3, 0, 0);
    run(13, 5, 1, 16'h7BDE, 1, 0);
    run(11, 3, 1, 16'hFFFF, 0, 0);
    run(9, 1, 1, 16'h0155, 1, 0);
    run(7, 0, 1, 16'h0000, 0, 0);
    run(10, 6, 0, '0, 1, 1);
    run(ME, 5, 1, 16'h3C96, 1, 1);
    run(0, 3, 1, 16'hFFFF, 0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule